// File: doc/BRIEF.md
# Dual-mode SPI serial clock generator

This block derives the serial clock of an SPI master from the module clock. It is driven by a divider configuration word and offers two division laws. The linear law divides by an even number 2*(N+1). The power-of-two law divides by 2^M. One select bit in the same word picks between them. Besides SCK, it produces two single-cycle enables, launch and sample, that tell a shift engine when to drive the next bit and when to capture the incoming one.

A transfer begins on the first clock edge at which `run` is high while the generator is idle. At that edge the divider word, CPOL and CPHA are captured, and they stay fixed until the transfer ends. SCK rests at the CPOL level whenever no transfer is running, so it cannot move before the bus is enabled. Once `run` is low, the generator stops at the next trailing SCK edge. A whole number of SCK periods is always produced.

Top module: `spiclk_gen`

## Requirements
- R1: With `div_cfg[12]` = 1 (linear law), the SCK period is 2*(N+1) module clocks, where N = `div_cfg[7:0]`, so each SCK level lasts N+1 clocks.
- R2: With `div_cfg[12]` = 0 (power-of-two law), the SCK period is 2^M module clocks for M = `div_cfg[11:8]` in 1..15, so each level lasts 2^(M-1) clocks.
- R3: In power-of-two mode, M = 0 gives the same divide-by-2 waveform as M = 1, with a 50 percent duty cycle.
- R4: Out of reset SCK, `launch_en` and `sample_en` are 0. While no transfer runs, SCK equals the CPOL input as registered on the previous clock edge.
- R5: A transfer starts at the first clock edge where `run` = 1 and the generator is idle. The first SCK edge, which moves away from CPOL, comes H clocks after that start edge, and later edges follow every H clocks, where H is the half-period from R1–R3.
- R6: `run` is examined only at trailing SCK edges (the return to CPOL). If it is 0 there, the transfer ends with SCK at CPOL. Dropping `run` earlier in a period still completes that period.
- R7: `launch_en` and `sample_en` are single-cycle pulses, high in the cycle in which SCK first shows its new level. With CPHA = 0 the sample pulse follows leading edges and the launch pulse follows trailing edges. With CPHA = 1 the two are swapped.
- R8: Changes to `div_cfg`, `cpol` or `cpha` during a transfer do not affect that transfer's waveform or pulses.
- R9: While idle, no launch or sample pulse is produced and SCK does not leave the CPOL level, whatever `div_cfg` does.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run | input | 1 | Start a transfer / keep it going |
| cpol | input | 1 | Idle level of SCK |
| cpha | input | 1 | Phase: selects which edge samples |
| div_cfg | input | 13 | [7:0] linear N, [11:8] exponent M, [12] law select (1 = linear) |
| sck | output | 1 | Serial clock |
| launch_en | output | 1 | One-cycle enable to drive the next bit |
| sample_en | output | 1 | One-cycle enable to capture a bit |

## Verification
SCK and both enables are registered. Each result therefore becomes visible in the cycle after the edge that decides it. The first SCK edge lands exactly H clock edges after the edge that samples `run`, and each later edge lands H edges after the previous one. The bench drives every input on the falling clock edge. For each cycle it numbers the rising edges from the start edge and checks SCK and both pulses against a model derived only from that edge index, H, CPOL and CPHA. It samples on the falling edge, half a cycle after each result is due. After the last trailing edge it keeps watching for a tail of idle cycles, so a late stop or a stray pulse is also caught.

// File: rtl/spiclk_pkg.sv
// Shared definitions for the SPI serial clock generator.
// Assumes: the law-select bit sits directly above the exponent field.
package spiclk_pkg;
    typedef enum logic {
        LAW_POW2   = 1'b0,
        LAW_LINEAR = 1'b1
    } div_law_e;
endpackage

// File: rtl/spiclk_half_calc.sv
// Half-period calculator: turns the divider fields into the number of
// module clocks that each SCK level lasts.
// Assumes: HALF_W can hold both N+1 and 2^((1<<EXP_W)-2).
module spiclk_half_calc
    import spiclk_pkg::*;
#(
    parameter int LIN_W  = 8,
    parameter int EXP_W  = 4,
    parameter int HALF_W = 15
) (
    input  logic [LIN_W-1:0]  lin_n,
    input  logic [EXP_W-1:0]  exp_m,
    input  div_law_e          law,
    output logic [HALF_W-1:0] half
);
    // Pick the half-period for the selected law; exponent 0 is folded onto 1.
    always_comb begin
        if (law == LAW_LINEAR) begin
            half = HALF_W'(lin_n) + HALF_W'(1);
        end else if (exp_m == '0) begin
            half = HALF_W'(1);
        end else begin
            half = HALF_W'(1) << (exp_m - EXP_W'(1));
        end
    end
endmodule

// File: rtl/spiclk_timer.sv
// Half-period timer: counts module clocks within each SCK level and
// flags leading and trailing edge ticks. It captures the half-period
// at transfer start and stops only on a trailing tick with run low.
// Assumes: half_in is never zero.
module spiclk_timer #(
    parameter int HALF_W = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [HALF_W-1:0] half_in,
    output logic              active,
    output logic              start,
    output logic              lead_tick,
    output logic              trail_tick
);
    logic [HALF_W-1:0] cnt;
    logic [HALF_W-1:0] half_q;
    logic              phase;   // 0: SCK at rest level, 1: SCK away from it
    logic              tick;

    // Decode the start condition and the edge ticks.
    always_comb begin
        start      = !active && run;
        tick       = active && (cnt == '0);
        lead_tick  = tick && !phase;
        trail_tick = tick && phase;
    end

    // Count clocks inside a level, advance the phase and end the transfer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            phase  <= 1'b0;
            cnt    <= '0;
            half_q <= HALF_W'(1);
        end else if (start) begin
            active <= 1'b1;
            phase  <= 1'b0;
            cnt    <= half_in - HALF_W'(1);
            half_q <= half_in;
        end else if (active) begin
            if (cnt == '0) begin
                cnt   <= half_q - HALF_W'(1);
                phase <= ~phase;
                if (phase && !run) begin
                    active <= 1'b0;
                end
            end else begin
                cnt <= cnt - HALF_W'(1);
            end
        end
    end

    // R5: the down-counter never reaches the captured half-period.
    assert_count_in_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> (cnt < half_q));

    // R6: an idle timer always rests in the rest-level phase.
    assert_rest_phase_when_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> !phase);
endmodule

// File: rtl/spiclk_edge.sv
// Edge generator: drives SCK and the launch/sample enables from the
// timer ticks, using CPOL/CPHA captured at transfer start.
// Assumes: start, lead_tick and trail_tick are mutually exclusive.
module spiclk_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic active,
    input  logic lead_tick,
    input  logic trail_tick,
    input  logic cpol,
    input  logic cpha,
    output logic sck,
    output logic launch_en,
    output logic sample_en
);
    logic cpol_q;
    logic cpha_q;

    // Capture the clock mode for the whole transfer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cpol_q <= 1'b0;
            cpha_q <= 1'b0;
        end else if (start) begin
            cpol_q <= cpol;
            cpha_q <= cpha;
        end
    end

    // Move SCK on ticks during a transfer; track live CPOL when idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck <= 1'b0;
        end else if (start) begin
            sck <= cpol;
        end else if (lead_tick) begin
            sck <= ~cpol_q;
        end else if (trail_tick) begin
            sck <= cpol_q;
        end else if (!active) begin
            sck <= cpol;
        end
    end

    // Route each tick to the launch or sample enable according to phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            launch_en <= 1'b0;
            sample_en <= 1'b0;
        end else begin
            launch_en <= cpha_q ? lead_tick  : trail_tick;
            sample_en <= cpha_q ? trail_tick : lead_tick;
        end
    end

    // R7: launch and sample never coincide.
    assert_pulses_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(launch_en && sample_en));

    // R7: every enable pulse coincides with a fresh SCK level.
    assert_pulse_on_edge_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (launch_en || sample_en) |-> !$stable(sck));

    // R5: between ticks of a running transfer SCK holds its level.
    assert_hold_between_ticks_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !lead_tick && !trail_tick) |=> $stable(sck));

    // R6: a transfer ends with SCK back at its captured rest level.
    assert_stop_at_rest_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(active) |-> (sck == cpol_q));
endmodule

// File: rtl/spiclk_gen.sv
// Dual-mode SPI serial clock generator top: splits the divider word,
// computes the half-period and connects the timer and edge generator.
// Assumes: div_cfg packs N low, M above it, law select on top.
module spiclk_gen
    import spiclk_pkg::*;
#(
    parameter int LIN_W = 8,
    parameter int EXP_W = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   run,
    input  logic                   cpol,
    input  logic                   cpha,
    input  logic [LIN_W+EXP_W:0]   div_cfg,
    output logic                   sck,
    output logic                   launch_en,
    output logic                   sample_en
);
    localparam int P2_W   = (1 << EXP_W) - 1;
    localparam int HALF_W = (LIN_W + 1 > P2_W) ? LIN_W + 1 : P2_W;

    logic [LIN_W-1:0]  lin_n;
    logic [EXP_W-1:0]  exp_m;
    div_law_e          law;
    logic [HALF_W-1:0] half;
    logic              active;
    logic              start;
    logic              lead_tick;
    logic              trail_tick;

    // Split the configuration word into its fields.
    always_comb begin
        lin_n = div_cfg[LIN_W-1:0];
        exp_m = div_cfg[LIN_W+EXP_W-1:LIN_W];
        law   = div_law_e'(div_cfg[LIN_W+EXP_W]);
    end

    spiclk_half_calc #(
        .LIN_W (LIN_W),
        .EXP_W (EXP_W),
        .HALF_W(HALF_W)
    ) u_half (
        .lin_n(lin_n),
        .exp_m(exp_m),
        .law  (law),
        .half (half)
    );

    spiclk_timer #(
        .HALF_W(HALF_W)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .half_in   (half),
        .active    (active),
        .start     (start),
        .lead_tick (lead_tick),
        .trail_tick(trail_tick)
    );

    spiclk_edge u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .active    (active),
        .lead_tick (lead_tick),
        .trail_tick(trail_tick),
        .cpol      (cpol),
        .cpha      (cpha),
        .sck       (sck),
        .launch_en (launch_en),
        .sample_en (sample_en)
    );

    // R9: no enable pulse outside a transfer once the timer is idle for a cycle.
    assert_quiet_when_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && !$past(active)) |-> (!launch_en && !sample_en));
endmodule

// File: tb/spiclk_gen_bench.sv
// Directed bench for the SPI serial clock generator.
module spiclk_gen_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run = 1'b0;
    logic        cpol = 1'b0;
    logic        cpha = 1'b0;
    logic [12:0] div_cfg = '0;
    logic        sck;
    logic        launch_en;
    logic        sample_en;

    int checks = 0;
    int failures = 0;

    always #10 clk = ~clk;

    spiclk_gen u_spiclk_gen (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .cpol     (cpol),
        .cpha     (cpha),
        .div_cfg  (div_cfg),
        .sck      (sck),
        .launch_en(launch_en),
        .sample_en(sample_en)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Run one transfer and compare every cycle with a model built from H.
    task automatic xfer(input string req, input logic lin, input int n, input int m,
                        input logic cp, input logic ph, input int periods,
                        input bit disturb, input bit drop_early);
        int h;
        int stop_cyc;
        int tail;
        int errs;
        int samples;
        int first_bad;
        logic [12:0] cfg;
        h = lin ? n + 1 : ((m == 0) ? 1 : (1 << (m - 1)));
        stop_cyc = 1 + 2 * periods * h;
        tail = (h < 8) ? 2 * h + 2 : 10;
        errs = 0;
        samples = 0;
        first_bad = -1;
        cfg = {lin, 4'(m), 8'(n)};
        @(negedge clk);
        div_cfg = cfg;
        cpol = cp;
        cpha = ph;
        repeat (2) @(negedge clk);
        run = 1'b1;
        for (int i = 1; i <= stop_cyc + tail; i++) begin
            int tgl;
            bit edge_now;
            bit lead;
            logic exp_sck;
            logic exp_l;
            logic exp_s;
            @(negedge clk);
            tgl = (i - 1) / h;
            edge_now = (i > 1) && ((i - 1) % h == 0) && (i <= stop_cyc);
            lead = edge_now && (tgl % 2 == 1);
            exp_sck = (i <= stop_cyc) ? (cp ^ logic'(tgl % 2)) : cp;
            exp_l = edge_now && (ph ? lead : !lead);
            exp_s = edge_now && (ph ? !lead : lead);
            if (sample_en) samples++;
            if (sck !== exp_sck || launch_en !== exp_l || sample_en !== exp_s) begin
                errs++;
                if (first_bad < 0) first_bad = i;
            end
            if (drop_early ? (i == 1) : (i == 1 + (2 * periods - 1) * h)) run = 1'b0;
            if (disturb && i == 2) begin
                div_cfg = 13'h1000;
                cpol = ~cp;
                cpha = ~ph;
            end
            if (disturb && i == stop_cyc - 1) begin
                div_cfg = cfg;
                cpol = cp;
                cpha = ph;
            end
        end
        check(errs == 0, req, "waveform mismatching cycles", errs, 0);
        check(samples == periods, req, "sample pulses per transfer", samples, periods);
        if (first_bad >= 0) $display("  first mismatch at cycle %0d (H=%0d)", first_bad, h);
    endtask

    task automatic t_reset();
        check(sck == 1'b0, "R4", "sck after reset", int'(sck), 0);
        check(!launch_en && !sample_en, "R4", "pulses after reset",
              int'({launch_en, sample_en}), 0);
    endtask

    task automatic t_idle();
        int moves;
        int pulses;
        logic last;
        @(negedge clk);
        cpol = 1'b1;
        @(negedge clk);
        check(sck == 1'b1, "R4", "idle sck follows cpol=1", int'(sck), 1);
        cpol = 1'b0;
        @(negedge clk);
        check(sck == 1'b0, "R4", "idle sck follows cpol=0", int'(sck), 0);
        moves = 0;
        pulses = 0;
        last = sck;
        for (int i = 0; i < 20; i++) begin
            div_cfg = 13'(i * 397);
            @(negedge clk);
            if (sck !== last) moves++;
            if (launch_en || sample_en) pulses++;
        end
        check(moves == 0, "R9", "idle sck movements", moves, 0);
        check(pulses == 0, "R9", "idle pulses", pulses, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_idle();
        xfer("R1 R5 R7", 1'b1, 0, 0, 1'b0, 1'b0, 2, 1'b0, 1'b0);
        xfer("R1 R7", 1'b1, 2, 0, 1'b1, 1'b1, 3, 1'b0, 1'b0);
        xfer("R1 boundary", 1'b1, 255, 0, 1'b0, 1'b1, 1, 1'b0, 1'b0);
        xfer("R3", 1'b0, 0, 0, 1'b0, 1'b0, 2, 1'b0, 1'b0);
        xfer("R2", 1'b0, 0, 1, 1'b1, 1'b0, 2, 1'b0, 1'b0);
        xfer("R2 R7", 1'b0, 0, 3, 1'b1, 1'b1, 2, 1'b0, 1'b0);
        xfer("R2 boundary", 1'b0, 0, 15, 1'b0, 1'b0, 1, 1'b0, 1'b0);
        xfer("R8", 1'b1, 3, 0, 1'b0, 1'b0, 2, 1'b1, 1'b0);
        xfer("R6", 1'b0, 0, 2, 1'b1, 1'b0, 1, 1'b0, 1'b1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog: actual=expired expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule